// File: doc/BRIEF.md
# Floating-Point Register Stack Tag Unit

This block holds the occupancy state and the top-of-stack pointer for an eight-entry stack of 80-bit extended-precision registers. Each cycle it accepts at most one stack action: a push of a new value, a pop, a write into a stack-relative register, or the load of a 16-bit tag word. Internally each register carries only one bit, which says whether it is empty or holds a value. When the tag word is read out, the full two-bit class of each register is rebuilt from the value that register currently holds.

Stack misuse is detected here. A push onto an occupied slot is an overflow. A pop of an empty slot, or a read of an empty slot, is an underflow. Either fault sets the invalid-operation and stack-fault flags in the status word, and C1 records the direction of the fault. The control word is held here too. Only its invalid-operation mask bit affects the block, and it decides whether a fault raises the exception request. The infinity-control bit can be stored and read back but does nothing.

Top module: `fpu_tag_stack`

## Requirements
- R1: After reset all eight registers are empty (`tagStoreWord` = 16'hFFFF), TOP = 0, status bits 0 (IE), 6 (SF) and 9 (C1) are 0, `ctrlWord` = 16'h037F and `excReq` = 0.
- R2: A push without a fault writes `pushData` into physical register (TOP-1) mod 8, marks that register non-empty, and sets TOP to (TOP-1) mod 8. TOP is status bits 13:11. ST(0) then reads back the pushed value.
- R3: A pop without a fault marks physical register TOP empty and sets TOP to (TOP+1) mod 8.
- R4: A push whose target register (TOP-1) mod 8 is non-empty is an overflow. It sets IE (bit 0), SF (bit 6) and C1 (bit 9) to 1, and it leaves TOP, the register contents and all tags unchanged.
- R5: A pop of an empty register ST(0), or a read (`readValid`) of an empty register ST(i), is an underflow. It sets IE and SF, clears C1, and leaves TOP and all tags unchanged.
- R6: A tag-word load marks register i empty when bits [2i+1:2i] are 11. It marks the register non-empty when those bits are 00, 01 or 10.
- R7: After a tag load, a non-empty register reports the class of its contents and not the loaded code. For example, a register that holds a finite normal value reports 00 even when it was loaded with 01.
- R8: `tagStoreWord` bits [2i+1:2i] describe physical register i. The codes are 11 for empty, 01 for zero (exponent 0, significand 0), 10 for special (exponent 7FFF, exponent 0 with a nonzero significand, or a nonzero exponent with integer bit 63 clear), and 00 for any other value.
- R9: Control bit 12 is written by `ctrlWrite` and reads back on `ctrlWord`. It does not change the tags, the TOP field or the fault behaviour.
- R10: `excReq` is high exactly when IE is set and control bit 0 (invalid-operation mask) is clear.
- R11: A register write to ST(i) stores `writeData` into physical register (TOP+i) mod 8 and marks it non-empty. It never faults, and TOP does not change.
- R12: When several requests arrive in the same cycle, only one takes effect. The order of precedence is tag load, then push, then pop, then register write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushData | input | 80 | Value to push |
| popValid | input | 1 | Pop request |
| writeValid | input | 1 | Write request to ST(writeIdx) |
| writeIdx | input | 3 | Stack-relative write index |
| writeData | input | 80 | Value to write |
| readValid | input | 1 | Read access to ST(readIdx); checked for underflow |
| readIdx | input | 3 | Stack-relative read index |
| readData | output | 80 | Contents of ST(readIdx) |
| tagLoadValid | input | 1 | Load tag word request |
| tagLoadWord | input | 16 | Tag word to load |
| tagStoreWord | output | 16 | Tag word rebuilt from register contents |
| ctrlWrite | input | 1 | Control word write strobe |
| ctrlIn | input | 16 | Control word value |
| ctrlWord | output | 16 | Stored control word |
| statusWord | output | 16 | IE bit 0, SF bit 6, C1 bit 9, TOP bits 13:11 |
| excReq | output | 1 | Unmasked invalid-operation request |

## Verification
The hardest case to reach is a tag word that disagrees with the register contents. From the ports this can only be set up by first filling the registers with values of known classes through pushes and writes, and then loading tag words over them. The stimulus therefore fills the whole stack with a class pattern that repeats. It then sweeps loaded tag codes, both uniform codes and mixed codes per register, and checks that the stored word follows the contents and ignores the loaded codes. A further pop on an all-empty load confirms that code 11 really empties the registers. A second hard case is the direction of C1. An overflow is first forced so that C1 is set, and a later underflow must then clear it.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int NumRegs = 8;
  localparam int RegW    = 80;
  localparam int ExpW    = 15;
  localparam int ManW    = RegW - ExpW - 1;
  localparam int IdxW    = $clog2(NumRegs);
  localparam int TagW    = 2 * NumRegs;
  localparam int WordW   = 16;
  localparam int IeBit   = 0;
  localparam int SfBit   = 6;
  localparam int C1Bit   = 9;
  localparam int TopLsb  = 11;
  localparam int MaskBit = 0;
  localparam logic [WordW-1:0] CtrlReset = 16'h037F;

  localparam logic [1:0] TagValid   = 2'b00;
  localparam logic [1:0] TagZero    = 2'b01;
  localparam logic [1:0] TagSpecial = 2'b10;
  localparam logic [1:0] TagEmpty   = 2'b11;

  typedef logic [IdxW-1:0] idx_t;

  typedef struct packed {
    logic doLoad;
    logic doPush;
    logic doPop;
    logic doWrite;
    logic faultOver;
    logic faultUnder;
    idx_t physIdx;
  } strobe_t;

  function automatic logic [1:0] classOf(input logic [RegW-1:0] v);
    logic [ExpW-1:0] e;
    logic [ManW-1:0] m;
    e = v[RegW-2 -: ExpW];
    m = v[ManW-1:0];
    if (e == '0 && m == '0) return TagZero;
    if (e == '1 || e == '0 || !m[ManW-1]) return TagSpecial;
    return TagValid;
  endfunction
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
(
  input  logic               pushValid,
  input  logic               popValid,
  input  logic               writeValid,
  input  idx_t               writeIdx,
  input  logic               readValid,
  input  idx_t               readIdx,
  input  logic               tagLoadValid,
  input  idx_t               top,
  input  logic [NumRegs-1:0] emptyVec,
  output strobe_t            strb,
  output idx_t               readPhys
);
  idx_t pushPhys, writePhys;

  always_comb begin
    pushPhys  = top - 1'b1;
    writePhys = top + writeIdx;
    readPhys  = top + readIdx;
    strb      = '0;
    if (tagLoadValid) begin
      strb.doLoad = 1'b1;
    end else if (pushValid) begin
      strb.physIdx = pushPhys;
      if (emptyVec[pushPhys]) strb.doPush = 1'b1;
      else                    strb.faultOver = 1'b1;
    end else if (popValid) begin
      strb.physIdx = top;
      if (emptyVec[top]) strb.faultUnder = 1'b1;
      else               strb.doPop = 1'b1;
    end else if (writeValid) begin
      strb.physIdx = writePhys;
      strb.doWrite = 1'b1;
    end else if (readValid) begin
      strb.physIdx    = readPhys;
      strb.faultUnder = emptyVec[readPhys];
    end
  end
endmodule

// File: rtl/fts_datapath.sv
module fts_datapath
  import fts_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [RegW-1:0]    pushData,
  input  logic [RegW-1:0]    writeData,
  input  logic [TagW-1:0]    tagLoadWord,
  input  logic               ctrlWrite,
  input  logic [WordW-1:0]   ctrlIn,
  input  idx_t               readPhys,
  output logic [NumRegs-1:0] emptyVec,
  output idx_t               top,
  output logic [RegW-1:0]    readData,
  output logic [TagW-1:0]    tagStoreWord,
  output logic [WordW-1:0]   statusWord,
  output logic [WordW-1:0]   ctrlWord,
  output logic               excReq
);
  logic [RegW-1:0] regFile [NumRegs];
  logic ieFlag, sfFlag, c1Flag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumRegs; i++) regFile[i] <= '0;
      emptyVec <= '1;
      top      <= '0;
      ieFlag   <= 1'b0;
      sfFlag   <= 1'b0;
      c1Flag   <= 1'b0;
      ctrlWord <= CtrlReset;
    end else begin
      if (strb.doLoad)
        for (int i = 0; i < NumRegs; i++) emptyVec[i] <= &tagLoadWord[2*i +: 2];
      if (strb.doPush) begin
        regFile[strb.physIdx]  <= pushData;
        emptyVec[strb.physIdx] <= 1'b0;
        top                    <= top - 1'b1;
      end
      if (strb.doPop) begin
        emptyVec[strb.physIdx] <= 1'b1;
        top                    <= top + 1'b1;
      end
      if (strb.doWrite) begin
        regFile[strb.physIdx]  <= writeData;
        emptyVec[strb.physIdx] <= 1'b0;
      end
      if (strb.faultOver || strb.faultUnder) begin
        ieFlag <= 1'b1;
        sfFlag <= 1'b1;
        c1Flag <= strb.faultOver;
      end
      if (ctrlWrite) ctrlWord <= ctrlIn;
    end
  end

  for (genvar g = 0; g < NumRegs; g++) begin : gTag
    assign tagStoreWord[2*g +: 2] = emptyVec[g] ? TagEmpty : classOf(regFile[g]);
  end

  assign readData = regFile[readPhys];
  assign excReq   = ieFlag && !ctrlWord[MaskBit];

  always_comb begin
    statusWord                 = '0;
    statusWord[IeBit]          = ieFlag;
    statusWord[SfBit]          = sfFlag;
    statusWord[C1Bit]          = c1Flag;
    statusWord[TopLsb +: IdxW] = top;
  end
endmodule

// File: rtl/fpu_tag_stack.sv
module fpu_tag_stack
  import fts_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushValid,
  input  logic [79:0]  pushData,
  input  logic         popValid,
  input  logic         writeValid,
  input  logic [2:0]   writeIdx,
  input  logic [79:0]  writeData,
  input  logic         readValid,
  input  logic [2:0]   readIdx,
  output logic [79:0]  readData,
  input  logic         tagLoadValid,
  input  logic [15:0]  tagLoadWord,
  output logic [15:0]  tagStoreWord,
  input  logic         ctrlWrite,
  input  logic [15:0]  ctrlIn,
  output logic [15:0]  ctrlWord,
  output logic [15:0]  statusWord,
  output logic         excReq
);
  strobe_t            strb;
  idx_t               readPhys;
  idx_t               top;
  logic [NumRegs-1:0] emptyVec;

  fts_ctrl u_ctrl (
    .pushValid(pushValid), .popValid(popValid), .writeValid(writeValid),
    .writeIdx(writeIdx), .readValid(readValid), .readIdx(readIdx),
    .tagLoadValid(tagLoadValid), .top(top), .emptyVec(emptyVec),
    .strb(strb), .readPhys(readPhys)
  );

  fts_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(pushData),
    .writeData(writeData), .tagLoadWord(tagLoadWord), .ctrlWrite(ctrlWrite),
    .ctrlIn(ctrlIn), .readPhys(readPhys), .emptyVec(emptyVec), .top(top),
    .readData(readData), .tagStoreWord(tagStoreWord), .statusWord(statusWord),
    .ctrlWord(ctrlWord), .excReq(excReq)
  );
endmodule

// File: rtl/fts_chk.sv
module fts_chk
  import fts_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input strobe_t      strb,
  input logic [15:0]  statusWord,
  input logic [15:0]  tagStoreWord,
  input logic [15:0]  ctrlWord,
  input logic         excReq
);
  idx_t topNow;
  assign topNow = statusWord[TopLsb +: IdxW];

  a_r2_push_top: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush |=> topNow == idx_t'($past(topNow) - 1'b1));

  a_r3_pop_top: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop |=> topNow == idx_t'($past(topNow) + 1'b1));

  a_r4_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.faultOver |=> statusWord[IeBit] && statusWord[SfBit] && statusWord[C1Bit]
                       && $stable(topNow) && $stable(tagStoreWord));

  a_r5_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.faultUnder |=> statusWord[IeBit] && statusWord[SfBit] && !statusWord[C1Bit]
                        && $stable(topNow) && $stable(tagStoreWord));

  a_r10_exc_req: assert property (@(posedge clk) disable iff (!rstN)
    excReq == (statusWord[IeBit] && !ctrlWord[MaskBit]));

  a_r11_write_keeps_top: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |=> $stable(topNow));

  a_r12_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doLoad, strb.doPush, strb.doPop, strb.doWrite, strb.faultOver, strb.faultUnder}));
endmodule

bind fpu_tag_stack fts_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .statusWord(statusWord),
  .tagStoreWord(tagStoreWord), .ctrlWord(ctrlWord), .excReq(excReq)
);

// File: tb/fpu_tag_stack_bench.sv
module fpu_tag_stack_bench;
  logic clk = 1'b0;
  logic rstN;
  logic pushValid, popValid, writeValid, readValid, tagLoadValid, ctrlWrite;
  logic [79:0] pushData, writeData, readData;
  logic [2:0]  writeIdx, readIdx;
  logic [15:0] tagLoadWord, tagStoreWord, ctrlIn, ctrlWord, statusWord;
  logic        excReq;

  int nChecks = 0;
  int nFail   = 0;

  logic [79:0] mRegs [8];
  logic [7:0]  mEmpty;
  int          mTop;

  always #5 clk = ~clk;

  fpu_tag_stack u_fpu_tag_stack (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popValid(popValid), .writeValid(writeValid), .writeIdx(writeIdx),
    .writeData(writeData), .readValid(readValid), .readIdx(readIdx),
    .readData(readData), .tagLoadValid(tagLoadValid), .tagLoadWord(tagLoadWord),
    .tagStoreWord(tagStoreWord), .ctrlWrite(ctrlWrite), .ctrlIn(ctrlIn),
    .ctrlWord(ctrlWord), .statusWord(statusWord), .excReq(excReq)
  );

  function automatic logic [1:0] benchClass(input logic [79:0] v);
    if (v[78:64] == 15'd0 && v[63:0] == 64'd0) return 2'b01;
    if (v[78:64] == 15'h7FFF)                  return 2'b10;
    if (v[78:64] == 15'd0)                     return 2'b10;
    if (v[63] == 1'b0)                         return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [79:0] pattern(input int k);
    case (k % 4)
      0:       return {1'b0, 15'h3FFF, 1'b1, 63'(k + 5)};
      1:       return 80'd0;
      2:       return {1'b1, 15'h7FFF, 1'b1, 63'd0};
      default: return {1'b0, 15'h0000, 1'b0, 63'(k + 1)};
    endcase
  endfunction

  function automatic logic [15:0] modelTags();
    logic [15:0] w;
    for (int i = 0; i < 8; i++)
      w[2*i +: 2] = mEmpty[i] ? 2'b11 : benchClass(mRegs[i]);
    return w;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pushValid = 0; popValid = 0; writeValid = 0; readValid = 0;
    tagLoadValid = 0; ctrlWrite = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    mEmpty = 8'hFF; mTop = 0;
    for (int i = 0; i < 8; i++) mRegs[i] = 80'd0;
  endtask

  task automatic push(input logic [79:0] v);
    pushValid = 1; pushData = v;
    @(negedge clk);
    idle();
  endtask

  task automatic pop();
    popValid = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic loadTags(input logic [15:0] w);
    tagLoadValid = 1; tagLoadWord = w;
    @(negedge clk);
    idle();
    for (int i = 0; i < 8; i++) mEmpty[i] = &w[2*i +: 2];
  endtask

  function automatic logic [2:0] topField();
    return statusWord[13:11];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    pushData = '0; writeData = '0; writeIdx = '0; readIdx = '0;
    tagLoadWord = '0; ctrlIn = '0;
    doReset();

    // R1 reset state
    check("R1 tags", 80'(tagStoreWord), 80'hFFFF);
    check("R1 status", 80'(statusWord), 80'h0);
    check("R1 ctrl", 80'(ctrlWord), 80'h037F);
    check("R1 excReq", 80'(excReq), 80'd0);

    // R2 R8 fill the stack
    for (int k = 0; k < 8; k++) begin
      push(pattern(k));
      mTop = (mTop + 7) % 8;
      mRegs[mTop] = pattern(k); mEmpty[mTop] = 0;
      check("R2 top", 80'(topField()), 80'(mTop));
      readIdx = 0; #1;
      check("R2 st0", readData, pattern(k));
      check("R8 tags", 80'(tagStoreWord), 80'(modelTags()));
    end

    // R4 overflow
    push(pattern(9));
    check("R4 flags", 80'({statusWord[9], statusWord[6], statusWord[0]}), 80'h7);
    check("R4 top", 80'(topField()), 80'(mTop));
    check("R4 tags", 80'(tagStoreWord), 80'(modelTags()));
    check("R10 masked", 80'(excReq), 80'd0);

    // R10 R9 control
    ctrlWrite = 1; ctrlIn = 16'h1000;
    @(negedge clk); idle();
    check("R10 unmasked", 80'(excReq), 80'd1);
    check("R9 readback", 80'(ctrlWord), 80'h1000);
    check("R9 tags", 80'(tagStoreWord), 80'(modelTags()));
    check("R9 top", 80'(topField()), 80'(mTop));

    // R11 writes to every ST(i)
    for (int i = 0; i < 8; i++) begin
      writeValid = 1; writeIdx = 3'(i); writeData = pattern(i + 2);
      @(negedge clk); idle();
      mRegs[(mTop + i) % 8] = pattern(i + 2);
      readIdx = 3'(i); #1;
      check("R11 data", readData, pattern(i + 2));
      check("R11 top", 80'(topField()), 80'(mTop));
      check("R11 tags", 80'(tagStoreWord), 80'(modelTags()));
    end

    // R3 pops
    for (int k = 0; k < 8; k++) begin
      pop();
      mEmpty[mTop] = 1; mTop = (mTop + 1) % 8;
      check("R3 top", 80'(topField()), 80'(mTop));
      check("R3 tags", 80'(tagStoreWord), 80'(modelTags()));
    end

    // R5 pop underflow clears C1 set by the earlier overflow
    pop();
    check("R5 flags", 80'({statusWord[9], statusWord[6], statusWord[0]}), 80'h3);
    check("R5 top", 80'(topField()), 80'(mTop));
    check("R5 tags", 80'(tagStoreWord), 80'hFFFF);

    // R5 read underflow
    doReset();
    readValid = 1; readIdx = 3;
    @(negedge clk); idle();
    check("R5 read flags", 80'({statusWord[9], statusWord[6], statusWord[0]}), 80'h3);
    check("R5 read excReq masked", 80'(excReq), 80'd0);

    // R11 write into an empty register
    doReset();
    writeValid = 1; writeIdx = 2; writeData = pattern(0);
    @(negedge clk); idle();
    mRegs[2] = pattern(0); mEmpty[2] = 0;
    check("R11 empty write", 80'(tagStoreWord), 80'(modelTags()));
    check("R11 no fault", 80'(statusWord[0]), 80'd0);

    // R6 R7 tag load sweep
    doReset();
    for (int k = 0; k < 8; k++) begin
      push(pattern(k));
      mTop = (mTop + 7) % 8; mRegs[mTop] = pattern(k); mEmpty[mTop] = 0;
    end
    for (int c = 0; c < 4; c++) begin
      loadTags({8{2'(c)}});
      check("R6 R7 uniform", 80'(tagStoreWord), 80'(modelTags()));
    end
    for (int w = 0; w < 16; w++) begin
      logic [15:0] word;
      for (int i = 0; i < 8; i++) word[2*i +: 2] = 2'((w + i * 3) % 4);
      loadTags(word);
      check("R6 R7 mixed", 80'(tagStoreWord), 80'(modelTags()));
    end
    loadTags(16'hFFFF);
    pop();
    check("R6 empty after load", 80'({statusWord[6], statusWord[0]}), 80'h3);
    check("R6 top", 80'(topField()), 80'(mTop));

    // R12 precedence
    doReset();
    tagLoadValid = 1; tagLoadWord = 16'hFFFC; pushValid = 1; pushData = pattern(0); popValid = 1;
    @(negedge clk); idle();
    check("R12 load wins tags", 80'(tagStoreWord), 80'hFFFD);
    check("R12 load wins top", 80'(topField()), 80'd0);
    pushValid = 1; pushData = pattern(0); popValid = 1; writeValid = 1; writeIdx = 0; writeData = pattern(2);
    @(negedge clk); idle();
    check("R12 push wins top", 80'(topField()), 80'd7);
    readIdx = 0; #1;
    check("R12 push wins data", readData, pattern(0));
    popValid = 1; writeValid = 1; writeIdx = 1; writeData = pattern(2);
    @(negedge clk); idle();
    check("R12 pop wins top", 80'(topField()), 80'd0);
    check("R12 pop wins tags", 80'(tagStoreWord[1:0]), 80'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule